// File: doc/BRIEF.md
# PCI Configuration Address Translator Bridge

This block is the host-side port through which software reaches PCI configuration space. It has two address regions: an index region, which holds one 32-bit configuration address word, and a data window. Software loads the address word into the index register. Each later read or write to the data window becomes one configuration request on a downstream interface. That request carries a translated 32-bit address, byte enables, write data positioned on its byte lanes, and a direction bit. The downstream side answers with a one-cycle acknowledge and a hit flag.

The translation depends on the format of the index word. A word with its top bit set is passed through. A word with its low bit set is treated as a type-1 address. Any other word is type-0: it selects a slot with a one-hot field in its upper bits. A lowest-set-bit encoder turns that field into a slot number, which is then repacked together with the function and register fields into the conventional layout. Data in the window is little-endian and right-justified on the host data bus. The host interface stalls while a window access is waiting for its acknowledge.

Top module: `cfg_xlate_bridge`

## Requirements
- R1: The index register resets to 0. An index-region write loads all 32 bits of `h_wdata`, whatever the access size. An index-region read returns the stored word. Every window access translates from the value held when that access is accepted, so an index write applies to the very next window access.
- R2: Pass-through format: when index bit 31 is 1, the translated address equals the index word with bits [1:0] replaced by window offset bits [1:0].
- R3: Type-1 format: when index bit 31 is 0 and bit 0 is 1, the translated address equals the index word with bits [2:0] replaced by window offset bits [2:0].
- R4: Type-0 format: when index bits 31 and 0 are both 0, the slot number S is the bit position (11 to 30) of the lowest set bit among index bits [31:11]. The translated address is (S << 11) OR (index[10:8] << 8) OR (index[7:3] << 3) OR offset[2:0].
- R5: In type-0 format, if index bits [31:11] are all 0, translated address bits [31:11] are all 1.
- R6: `h_size` encodes 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. The byte lane is window offset bits [1:0]. The byte enable is 0001, 0011 or 1111 shifted left by the lane.
- R7: Little-endian ordering: for a write, `h_wdata[7:0]` goes to the byte lane given by the offset and higher bytes follow upward. A read returns the accessed bytes right-justified in `h_rdata`, with the bytes above the access size set to 0.
- R8: An access is rejected when it is 2 bytes at lane 3, 4 bytes at a lane other than 0, or has `h_size` = 3. A rejected access completes with `h_err` = 1 and issues no downstream request.
- R9: A window access holds `h_busy` high and `d_req` high, with a stable address, until `d_ack`. `h_done` is a single-cycle pulse that ends every accepted access.
- R10: A window read acknowledged with `d_hit` = 0 returns all ones in the accessed bytes.
- R11: `h_addr` bit 12 selects the region (0 = index, 1 = data window). Bits [11:0] are the offset within the 4 KiB region, and any offset in the index region reaches the index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_req | input | 1 | Host access strobe, taken when `h_busy` is low |
| h_we | input | 1 | Host access is a write |
| h_addr | input | 13 | Region select (bit 12) and offset within the region |
| h_size | input | 2 | Access size code |
| h_wdata | input | 32 | Host write data, right-justified |
| h_busy | output | 1 | Access in progress |
| h_done | output | 1 | Access complete pulse |
| h_err | output | 1 | Completed access was rejected |
| h_rdata | output | 32 | Read data, valid with `h_done` |
| d_req | output | 1 | Downstream configuration request pending |
| d_we | output | 1 | Downstream request is a write |
| d_addr | output | 32 | Translated configuration address |
| d_be | output | 4 | Downstream byte enables |
| d_wdata | output | 32 | Downstream write data on byte lanes |
| d_ack | input | 1 | Downstream completion, one cycle |
| d_hit | input | 1 | A device answered the request |
| d_rdata | input | 32 | Downstream read data on byte lanes |

## Verification
The bench builds the block with its default parameters: a 12-bit region offset, a slot field starting at bit 11, and a function field at bits [10:8]. These values give every slot position from 11 to 30, the empty-slot case, and all four byte lanes, so the reachable corners are the ends of the one-hot field, a wrapped halfword at lane 3, and a word at lanes 1 to 3. A bench device model with a programmable acknowledge delay and a programmable hit flag exercises the stall path and the no-device read.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    localparam int WORD_W  = 32;
    localparam int LANES   = WORD_W / 8;
    localparam int LANE_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        FMT_PASS  = 2'd0,
        FMT_TYPE1 = 2'd1,
        FMT_TYPE0 = 2'd2
    } idx_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } txn_state_e;

    typedef struct packed {
        logic              we;
        logic [WORD_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [WORD_W-1:0] wdata;
    } dreq_t;

    function automatic logic [WORD_W-1:0] size_mask(acc_size_e sz);
        case (sz)
            SZ_BYTE: size_mask = WORD_W'(8'hFF);
            SZ_HALF: size_mask = WORD_W'(16'hFFFF);
            default: size_mask = '1;
        endcase
    endfunction

    function automatic logic [LANES-1:0] base_be(acc_size_e sz);
        case (sz)
            SZ_BYTE: base_be = LANES'(1);
            SZ_HALF: base_be = LANES'(3);
            default: base_be = '1;
        endcase
    endfunction

endpackage

// File: rtl/cfgx_slot_enc.sv
module cfgx_slot_enc #(
    parameter int W   = 32,
    parameter int LSB = 11
) (
    input  logic [W-1:0] vec,
    output logic [W-1:0] slot
);
    localparam int PW = $clog2(W);

    logic          seen [LSB:W];
    logic [PW-1:0] acc  [LSB:W];

    assign seen[LSB] = 1'b0;
    assign acc[LSB]  = '0;

    for (genvar i = LSB; i < W; i++) begin : g_bit
        logic first;
        assign first      = vec[i] & ~seen[i];
        assign seen[i+1]  = seen[i] | vec[i];
        assign acc[i+1]   = acc[i] | (first ? PW'(i) : '0);
    end

    assign slot = seen[W] ? W'(acc[W]) : '1;

    always_comb begin
        if (seen[W]) begin
            assert_slot_is_set_R4: assert (vec[acc[W]] && (acc[W] >= PW'(LSB)));
        end
    end
endmodule

// File: rtl/cfgx_addr_xlate.sv
module cfgx_addr_xlate
    import cfgx_pkg::*;
#(
    parameter int SLOT_LSB = 11,
    parameter int FN_LSB   = 8
) (
    input  logic [WORD_W-1:0] idx,
    input  logic [2:0]        ofs_lo,
    output idx_fmt_e          fmt,
    output logic [WORD_W-1:0] addr
);
    localparam int REG_W = FN_LSB;

    logic [WORD_W-1:0] slot;
    logic [WORD_W-1:0] fn_part;
    logic [WORD_W-1:0] reg_part;

    cfgx_slot_enc #(.W(WORD_W), .LSB(SLOT_LSB)) u_slot (
        .vec  (idx),
        .slot (slot)
    );

    assign fn_part  = WORD_W'(idx[SLOT_LSB-1:FN_LSB]) << FN_LSB;
    assign reg_part = WORD_W'({idx[REG_W-1:3], ofs_lo});

    always_comb begin
        if (idx[WORD_W-1]) begin
            fmt  = FMT_PASS;
            addr = {idx[WORD_W-1:2], ofs_lo[1:0]};
        end else if (idx[0]) begin
            fmt  = FMT_TYPE1;
            addr = {idx[WORD_W-1:3], ofs_lo};
        end else begin
            fmt  = FMT_TYPE0;
            addr = (slot << SLOT_LSB) | fn_part | reg_part;
        end
    end

    always_comb begin
        if (!idx[WORD_W-1] && !idx[0] && (idx[WORD_W-1:SLOT_LSB] == '0)) begin
            assert_noslot_fill_R5: assert (&addr[WORD_W-1:SLOT_LSB]);
        end
        if (idx[WORD_W-1]) begin
            assert_pass_low_R2: assert (addr[1:0] == ofs_lo[1:0] && addr[WORD_W-1]);
        end
    end
endmodule

// File: rtl/cfgx_lane_align.sv
module cfgx_lane_align
    import cfgx_pkg::*;
(
    input  acc_size_e          size,
    input  logic [LANE_W-1:0]  lane,
    input  logic [WORD_W-1:0]  wdata_in,
    output logic [LANES-1:0]   be,
    output logic               misalign,
    output logic [WORD_W-1:0]  wdata_out,
    input  acc_size_e          rd_size,
    input  logic [LANE_W-1:0]  rd_lane,
    input  logic [WORD_W-1:0]  rd_word,
    output logic [WORD_W-1:0]  rd_out
);
    localparam int SH_W = LANE_W + 3;

    logic [SH_W-1:0] wr_shift;
    logic [SH_W-1:0] rd_shift;

    assign wr_shift = {lane, 3'b000};
    assign rd_shift = {rd_lane, 3'b000};

    always_comb begin
        case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = (lane == LANE_W'(LANES - 1));
            SZ_WORD: misalign = (lane != '0);
            default: misalign = 1'b1;
        endcase
        be        = LANES'(base_be(size) << lane);
        wdata_out = wdata_in << wr_shift;
        rd_out    = (rd_word >> rd_shift) & size_mask(rd_size);
    end

    always_comb begin
        if (!misalign) begin
            assert_be_width_R6: assert ($countones(be) == (1 << size));
        end
    end
endmodule

// File: rtl/cfgx_txn_ctrl.sv
module cfgx_txn_ctrl
    import cfgx_pkg::*;
#(
    parameter int OFS_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  logic              h_sel_win,
    input  acc_size_e         h_size,
    input  logic [LANE_W-1:0] h_lane,
    input  logic [WORD_W-1:0] h_wdata,
    input  logic [WORD_W-1:0] x_addr,
    input  logic [LANES-1:0]  x_be,
    input  logic              x_misalign,
    input  logic [WORD_W-1:0] x_wdata,
    input  logic [WORD_W-1:0] rd_fmt,
    input  logic              d_ack,
    output logic [WORD_W-1:0] idx_q,
    output acc_size_e         rd_size_q,
    output logic [LANE_W-1:0] rd_lane_q,
    output dreq_t             dreq_q,
    output logic              h_busy,
    output logic              h_done,
    output logic              h_err,
    output logic [WORD_W-1:0] h_rdata,
    output logic              d_req
);
    txn_state_e        state;
    logic              err_q;
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            idx_q     <= '0;
            err_q     <= 1'b0;
            rdata_q   <= '0;
            dreq_q    <= '0;
            rd_size_q <= SZ_BYTE;
            rd_lane_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (h_req) begin
                        state <= ST_RESP;
                        err_q <= 1'b0;
                        if (!h_sel_win) begin
                            rdata_q <= idx_q;
                            if (h_we) begin
                                idx_q <= h_wdata;
                            end
                        end else if (x_misalign) begin
                            err_q <= 1'b1;
                        end else begin
                            state        <= ST_WAIT;
                            dreq_q.we    <= h_we;
                            dreq_q.addr  <= x_addr;
                            dreq_q.be    <= x_be;
                            dreq_q.wdata <= x_wdata;
                            rd_size_q    <= h_size;
                            rd_lane_q    <= h_lane;
                        end
                    end
                end
                ST_WAIT: begin
                    if (d_ack) begin
                        state <= ST_RESP;
                        if (!dreq_q.we) begin
                            rdata_q <= rd_fmt;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign d_req   = (state == ST_WAIT);
    assign h_busy  = (state != ST_IDLE);
    assign h_done  = (state == ST_RESP);
    assign h_err   = err_q;
    assign h_rdata = rdata_q;

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        d_req && !d_ack |=> d_req && $stable(dreq_q.addr) && $stable(dreq_q.be));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        h_done |=> !h_done);

    assert_err_noreq_R8: assert property (@(posedge clk) disable iff (rst)
        h_done && h_err |-> !$past(d_req));

    assert_be_legal_R6: assert property (@(posedge clk) disable iff (rst)
        d_req |-> ($countones(dreq_q.be) == 1 || $countones(dreq_q.be) == 2
                   || $countones(dreq_q.be) == 4));

    assert_idx_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> idx_q == '0);
endmodule

// File: rtl/cfg_xlate_bridge.sv
module cfg_xlate_bridge
    import cfgx_pkg::*;
#(
    parameter int OFS_W    = 12,
    parameter int SLOT_LSB = 11,
    parameter int FN_LSB   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              h_req,
    input  logic              h_we,
    input  logic [OFS_W:0]    h_addr,
    input  logic [1:0]        h_size,
    input  logic [WORD_W-1:0] h_wdata,
    output logic              h_busy,
    output logic              h_done,
    output logic              h_err,
    output logic [WORD_W-1:0] h_rdata,
    output logic              d_req,
    output logic              d_we,
    output logic [WORD_W-1:0] d_addr,
    output logic [LANES-1:0]  d_be,
    output logic [WORD_W-1:0] d_wdata,
    input  logic              d_ack,
    input  logic              d_hit,
    input  logic [WORD_W-1:0] d_rdata
);
    logic [WORD_W-1:0] idx_q;
    idx_fmt_e          fmt;
    logic [WORD_W-1:0] x_addr;
    logic [LANES-1:0]  x_be;
    logic              x_misalign;
    logic [WORD_W-1:0] x_wdata;
    logic [WORD_W-1:0] rd_word;
    logic [WORD_W-1:0] rd_fmt;
    acc_size_e         h_size_e;
    acc_size_e         rd_size_q;
    logic [LANE_W-1:0] rd_lane_q;
    dreq_t             dreq_q;
    logic              unused_ok;

    assign h_size_e  = acc_size_e'(h_size);
    assign rd_word   = d_hit ? d_rdata : '1;
    assign unused_ok = ^{fmt};

    cfgx_addr_xlate #(.SLOT_LSB(SLOT_LSB), .FN_LSB(FN_LSB)) u_xlate (
        .idx    (idx_q),
        .ofs_lo (h_addr[2:0]),
        .fmt    (fmt),
        .addr   (x_addr)
    );

    cfgx_lane_align u_lane (
        .size      (h_size_e),
        .lane      (h_addr[LANE_W-1:0]),
        .wdata_in  (h_wdata),
        .be        (x_be),
        .misalign  (x_misalign),
        .wdata_out (x_wdata),
        .rd_size   (rd_size_q),
        .rd_lane   (rd_lane_q),
        .rd_word   (rd_word),
        .rd_out    (rd_fmt)
    );

    cfgx_txn_ctrl #(.OFS_W(OFS_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .h_req      (h_req),
        .h_we       (h_we),
        .h_sel_win  (h_addr[OFS_W]),
        .h_size     (h_size_e),
        .h_lane     (h_addr[LANE_W-1:0]),
        .h_wdata    (h_wdata),
        .x_addr     (x_addr),
        .x_be       (x_be),
        .x_misalign (x_misalign),
        .x_wdata    (x_wdata),
        .rd_fmt     (rd_fmt),
        .d_ack      (d_ack),
        .idx_q      (idx_q),
        .rd_size_q  (rd_size_q),
        .rd_lane_q  (rd_lane_q),
        .dreq_q     (dreq_q),
        .h_busy     (h_busy),
        .h_done     (h_done),
        .h_err      (h_err),
        .h_rdata    (h_rdata),
        .d_req      (d_req)
    );

    assign d_we    = dreq_q.we;
    assign d_addr  = dreq_q.addr;
    assign d_be    = dreq_q.be;
    assign d_wdata = dreq_q.wdata;
endmodule

// File: tb/test_cfg_xlate_bridge.sv
module test_cfg_xlate_bridge;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DEV_DATA = 32'h4433_2211;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_req = 1'b0;
    logic        h_we = 1'b0;
    logic [12:0] h_addr = '0;
    logic [1:0]  h_size = '0;
    logic [31:0] h_wdata = '0;
    logic        h_busy, h_done, h_err;
    logic [31:0] h_rdata;
    logic        d_req, d_we;
    logic [31:0] d_addr, d_wdata;
    logic [3:0]  d_be;
    logic        d_ack = 1'b0;
    logic        d_hit = 1'b0;
    logic [31:0] d_rdata = DEV_DATA;

    int checks = 0;
    int fails  = 0;
    int dev_wait = 0;
    bit dev_present = 1'b1;
    int dly_cnt = 0;
    int req_cycles = 0;
    int unstable = 0;
    int busy_cycles = 0;
    logic [31:0] seen_addr, seen_wdata;
    logic [3:0]  seen_be;
    logic        seen_we;
    logic [31:0] rd;
    logic        er;

    cfg_xlate_bridge i_cfg_xlate_bridge (
        .clk(clk), .rst(rst), .h_req(h_req), .h_we(h_we), .h_addr(h_addr),
        .h_size(h_size), .h_wdata(h_wdata), .h_busy(h_busy), .h_done(h_done),
        .h_err(h_err), .h_rdata(h_rdata), .d_req(d_req), .d_we(d_we),
        .d_addr(d_addr), .d_be(d_be), .d_wdata(d_wdata), .d_ack(d_ack),
        .d_hit(d_hit), .d_rdata(d_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // downstream device model
    always @(negedge clk) begin
        if (d_ack) begin
            d_ack = 1'b0;
        end else if (d_req) begin
            req_cycles++;
            if (req_cycles > 1 && (d_addr !== seen_addr || d_be !== seen_be)) unstable++;
            seen_addr = d_addr; seen_be = d_be; seen_we = d_we; seen_wdata = d_wdata;
            if (dly_cnt >= dev_wait) begin
                d_ack = 1'b1;
                d_hit = dev_present;
                dly_cnt = 0;
            end else begin
                dly_cnt++;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // one host access; returns data and error flag
    task automatic access(bit win, bit we, logic [11:0] ofs, logic [1:0] sz,
                          logic [31:0] wd, output logic [31:0] rdo, output logic erro);
        int guard = 0;
        req_cycles = 0;
        busy_cycles = 0;
        unstable = 0;
        h_req = 1'b1; h_we = we; h_addr = {win, ofs}; h_size = sz; h_wdata = wd;
        @(negedge clk);
        h_req = 1'b0;
        while (!h_done && guard < 1000) begin
            if (h_busy) busy_cycles++;
            guard++;
            @(negedge clk);
        end
        rdo = h_rdata;
        erro = h_err;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 reset busy", 32'(h_busy), 0);
        check("R9 reset d_req", 32'(d_req), 0);
        access(0, 0, 12'h010, 2, 0, rd, er);
        check("R1 index reset value", rd, 32'h0);
    endtask

    task automatic t_index();
        access(0, 1, 12'hFFC, 0, 32'hCAFE_F00D, rd, er);
        access(0, 0, 12'h000, 2, 0, rd, er);
        check("R1 R11 index full word readback", rd, 32'hCAFE_F00D);
        check("R1 index no error", 32'(er), 0);
    endtask

    task automatic t_pass();
        access(0, 1, 12'h7FC, 2, 32'h8000_1234, rd, er);
        access(1, 0, 12'h000, 2, 0, rd, er);
        check("R2 pass addr word", seen_addr, 32'h8000_1234);
        check("R6 be word", 32'(seen_be), 32'hF);
        check("R7 read word", rd, DEV_DATA);
        access(1, 0, 12'h002, 1, 0, rd, er);
        check("R2 pass addr half", seen_addr, 32'h8000_1236);
        check("R6 be half lane2", 32'(seen_be), 32'hC);
        check("R7 read half right-justified", rd, 32'h0000_4433);
        access(1, 0, 12'hFFD, 0, 0, rd, er);
        check("R11 R2 high window offset", seen_addr, 32'h8000_1235);
        check("R6 be byte lane1", 32'(seen_be), 32'h2);
        check("R7 read byte", rd, 32'h0000_0022);
    endtask

    task automatic t_type1();
        access(0, 1, 12'h000, 2, 32'h0012_3455, rd, er);
        access(1, 0, 12'h006, 0, 0, rd, er);
        check("R3 type1 addr", seen_addr, 32'h0012_3456);
        check("R6 be byte lane2", 32'(seen_be), 32'h4);
        check("R7 byte lane2 data", rd, 32'h0000_0033);
        access(1, 1, 12'h004, 2, 32'hDEAD_BEEF, rd, er);
        check("R3 type1 write addr", seen_addr, 32'h0012_3454);
        check("R7 write word data", seen_wdata, 32'hDEAD_BEEF);
        check("R3 write direction", 32'(seen_we), 1);
    endtask

    task automatic t_type0();
        access(0, 1, 12'h000, 2, 32'h0010_453C, rd, er);
        access(1, 1, 12'h001, 0, 32'h0000_00AB, rd, er);
        check("R4 type0 lowest slot bit14", seen_addr, 32'h0000_7539);
        check("R6 be byte lane1", 32'(seen_be), 32'h2);
        check("R7 write byte on lane1", seen_wdata, 32'h0000_AB00);
        access(0, 1, 12'h000, 2, 32'h0000_0800, rd, er);
        access(1, 0, 12'h004, 2, 0, rd, er);
        check("R4 type0 slot bit11", seen_addr, 32'h0000_5804);
        access(0, 1, 12'h000, 2, 32'h4000_0000, rd, er);
        access(1, 0, 12'h000, 1, 0, rd, er);
        check("R4 type0 slot bit30", seen_addr, 32'h0000_F000);
        check("R6 be half lane0", 32'(seen_be), 32'h3);
        check("R7 half lane0 data", rd, 32'h0000_2211);
    endtask

    task automatic t_noslot();
        access(0, 1, 12'h000, 2, 32'h0000_0710, rd, er);
        access(1, 0, 12'h003, 0, 0, rd, er);
        check("R5 empty slot field fills ones", seen_addr, 32'hFFFF_FF13);
        check("R6 be byte lane3", 32'(seen_be), 32'h8);
        check("R7 byte lane3 data", rd, 32'h0000_0044);
    endtask

    task automatic t_misalign();
        access(1, 0, 12'h003, 1, 0, rd, er);
        check("R8 half at lane3 error", 32'(er), 1);
        check("R8 half at lane3 no request", 32'(req_cycles), 0);
        access(1, 1, 12'h002, 2, 32'h1111_1111, rd, er);
        check("R8 word at lane2 error", 32'(er), 1);
        check("R8 word at lane2 no request", 32'(req_cycles), 0);
        access(1, 0, 12'h000, 3, 0, rd, er);
        check("R8 size code 3 error", 32'(er), 1);
        check("R8 size code 3 no request", 32'(req_cycles), 0);
        access(1, 0, 12'h002, 1, 0, rd, er);
        check("R8 half at lane2 accepted", 32'(er), 0);
        check("R8 half at lane2 one request", 32'(req_cycles), 1);
    endtask

    task automatic t_nohit();
        dev_present = 1'b0;
        access(1, 0, 12'h002, 1, 0, rd, er);
        check("R10 no device half", rd, 32'h0000_FFFF);
        access(1, 0, 12'h000, 2, 0, rd, er);
        check("R10 no device word", rd, 32'hFFFF_FFFF);
        dev_present = 1'b1;
    endtask

    task automatic t_stall();
        dev_wait = 5;
        access(1, 0, 12'h000, 2, 0, rd, er);
        check("R9 request held until ack", 32'(req_cycles), 6);
        check("R9 address stable while waiting", 32'(unstable), 0);
        check("R9 busy during wait", 32'(busy_cycles), 6);
        check("R9 done is one pulse", 32'(h_done), 0);
        check("R9 read data after stall", rd, DEV_DATA);
        dev_wait = 0;
    endtask

    task automatic t_index_immediate();
        access(0, 1, 12'h000, 2, 32'h8000_0000, rd, er);
        access(0, 1, 12'h000, 2, 32'h8ABC_0000, rd, er);
        access(1, 0, 12'h000, 2, 0, rd, er);
        check("R1 newest index used at once", seen_addr, 32'h8ABC_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_index();
        t_pass();
        t_type1();
        t_type0();
        t_noslot();
        t_misalign();
        t_nohit();
        t_stall();
        t_index_immediate();
        finish_run();
    end
endmodule